// File: doc/BRIEF.md
# Memory Performance Counter Unit

This block watches a memory controller and counts what it does. It holds one cycle counter and several event counters. All of them are reached through a small register bus that uses byte addresses aligned to words. Each event counter is given an 8-bit event code in its control register. The code selects one of the single-cycle event pulses from the controller, or it selects a read or write transaction stream whose ID must equal a programmable match value.

The cycle counter is the master. Event counters advance only while it is enabled. When the cycle counter wraps, it stops itself and sets its overflow flag. The flag drives the only interrupt, so every counter stops until software restarts the cycle counter. A counter takes a new start command only when its enable bit goes from 0 to 1. A start with the clear bit set also zeroes the counter.

Top module: `mpc_perfmon`

## Requirements
- R1: After reset all counters read zero, all enables and flags read zero, the match value reads zero and `irq` is low.
- R2: Address map (byte offsets): control of counter n at 4·n, value of counter n at 0x20+4·n, transaction-ID match value at 0x30. Any other offset reads zero. `bus_rdata`/`bus_rvalid` appear exactly one cycle after a read request.
- R3: Control word fields: bit 0 is the overflow flag (writing 1 clears it), bit 1 is clear (always reads 0), bit 2 is enable, bits 31:24 are the event code. Counter 0 always reports code 0x00.
- R4: Writing enable=1 with clear=1 to a stopped counter zeroes it and starts it. Writing enable=1 with clear=0 starts it from its held value.
- R5: Writing enable=1 to a counter that is already enabled changes neither its value, its enable nor its event code.
- R6: Counter 0 increments once per clock while enabled.
- R7: Counters 1 to 3 change only while counter 0 is enabled. While counter 0 is stopped, every counter holds its value.
- R8: Event codes: 0x00 counts every cycle, 0x04 `ev_pulse[0]` (read access), 0x05 `ev_pulse[1]` (write access), 0x31 `ev_pulse[2]` (precharge), 0x32 `ev_pulse[3]` (activate), 0x37 `ev_pulse[4]` (refresh). Any other code never counts, apart from the two ID-filtered codes in R9.
- R9: Code 0x41 counts cycles with `rd_xact_v` high and `rd_xact_id` equal to the match value. Code 0x42 does the same using `wr_xact_v` and `wr_xact_id`.
- R10: When counter 0 increments from all ones it wraps to 0, sets its overflow flag and clears its own enable, which halts all counting. `irq` is high exactly while that flag is set.
- R11: The overflow flag is cleared by writing 1 to control bit 0 of counter 0, or by re-enabling counter 0. Re-enabling resumes counting.
- R12: An event counter that wraps rolls over to 0, keeps counting and does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ev_pulse | input | 5 | Single-cycle controller event pulses (mapping in R8) |
| rd_xact_v | input | 1 | Read transaction accepted this cycle |
| rd_xact_id | input | ID_W | ID of that read transaction |
| wr_xact_v | input | 1 | Write transaction accepted this cycle |
| wr_xact_id | input | ID_W | ID of that write transaction |
| irq | output | 1 | Level interrupt: cycle counter overflow flag |

## Verification
The bench builds the unit with 8-bit counters and a 4-bit transaction ID. At 8 bits the cycle counter wraps within a few hundred clocks, so the overflow halt, the interrupt level and both ways of clearing the flag are all exercised. An event counter left near all ones from before the overflow then wraps while the cycle counter runs from zero. With a 4-bit ID, pseudo-random transaction IDs hit the match value often enough that the filtered codes give non-trivial counts.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;
   localparam int BUS_W    = 32;
   localparam int CODE_W   = 8;
   localparam int SEL_LSB  = 24;
   localparam int OVF_BIT  = 0;
   localparam int CLR_BIT  = 1;
   localparam int EN_BIT   = 2;
   localparam int NUM_EV   = 5;

   localparam int CTRL_BASE = 'h00;
   localparam int VAL_BASE  = 'h20;
   localparam int FILT_OFF  = 'h30;

   localparam logic [CODE_W-1:0] EVC_CYCLES  = 8'h00;
   localparam logic [CODE_W-1:0] EVC_RD_ACC  = 8'h04;
   localparam logic [CODE_W-1:0] EVC_WR_ACC  = 8'h05;
   localparam logic [CODE_W-1:0] EVC_PRECHG  = 8'h31;
   localparam logic [CODE_W-1:0] EVC_ACT     = 8'h32;
   localparam logic [CODE_W-1:0] EVC_REFRESH = 8'h37;
   localparam logic [CODE_W-1:0] EVC_ID_RD   = 8'h41;
   localparam logic [CODE_W-1:0] EVC_ID_WR   = 8'h42;

   typedef struct packed {
      logic [CODE_W-1:0] sel;
      logic              en;
      logic              ovf;
   } mpc_stat_t;
endpackage

// File: rtl/mpc_evsel.sv
`timescale 1ns/1ps
module mpc_evsel
   import mpc_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [NUM_EV-1:0] ev_pulse_i,
   input  logic              rd_xact_v_i,
   input  logic [ID_W-1:0]   rd_xact_id_i,
   input  logic              wr_xact_v_i,
   input  logic [ID_W-1:0]   wr_xact_id_i,
   input  logic [ID_W-1:0]   match_id_i,
   output logic              hit_o
);
   always_comb begin
      case (code_i)
         EVC_CYCLES:  hit_o = 1'b1;
         EVC_RD_ACC:  hit_o = ev_pulse_i[0];
         EVC_WR_ACC:  hit_o = ev_pulse_i[1];
         EVC_PRECHG:  hit_o = ev_pulse_i[2];
         EVC_ACT:     hit_o = ev_pulse_i[3];
         EVC_REFRESH: hit_o = ev_pulse_i[4];
         EVC_ID_RD:   hit_o = rd_xact_v_i && (rd_xact_id_i == match_id_i);
         EVC_ID_WR:   hit_o = wr_xact_v_i && (wr_xact_id_i == match_id_i);
         default:     hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/mpc_slice.sv
`timescale 1ns/1ps
module mpc_slice
   import mpc_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit IS_CYCLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl_i,
   input  logic              wr_en_i,
   input  logic              wr_clr_i,
   input  logic              wr_ovf_i,
   input  logic [CODE_W-1:0] wr_sel_i,
   input  logic              gate_i,
   input  logic              hit_i,
   output logic [CNT_W-1:0]  cnt_o,
   output mpc_stat_t         stat_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             start, stop, inc, wrap;

   assign start = wr_ctrl_i && wr_en_i && !en_q;
   assign stop  = wr_ctrl_i && !wr_en_i;
   assign inc   = en_q && gate_i && hit_i;
   assign wrap  = inc && (cnt_q == CMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (start) begin
         en_q <= 1'b1;
         if (wr_clr_i) cnt_q <= '0;
      end else if (stop) begin
         en_q <= 1'b0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
         if (IS_CYCLE && wrap) en_q <= 1'b0;
      end
   end

   assign cnt_o     = cnt_q;
   assign stat_o.en = en_q;

   generate
      if (IS_CYCLE) begin : g_cyc
         logic ovf_q;
         logic unused_sel;
         assign unused_sel = ^wr_sel_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ovf_q <= 1'b0;
            else if (wrap)                          ovf_q <= 1'b1;
            else if (start || (wr_ctrl_i && wr_ovf_i)) ovf_q <= 1'b0;
         end
         assign stat_o.ovf = ovf_q;
         assign stat_o.sel = EVC_CYCLES;

         assert_ovf_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_q) |-> (!en_q && cnt_q == '0));
      end else begin : g_evt
         logic [CODE_W-1:0] sel_q;
         logic unused_ovf;
         assign unused_ovf = wr_ovf_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sel_q <= '0;
            else if (start) sel_q <= wr_sel_i;
         end
         assign stat_o.ovf = 1'b0;
         assign stat_o.sel = sel_q;
      end
   endgenerate

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctrl_i && !(en_q && gate_i && hit_i)) |=> $stable(cnt_q));

   assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl_i && wr_en_i && en_q && !wrap) |=> (en_q && $stable(stat_o.sel)));
endmodule

// File: rtl/mpc_perfmon.sv
`timescale 1ns/1ps
module mpc_perfmon
   import mpc_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int ID_W    = 8,
   parameter int ADDR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_rvalid,
   input  logic [NUM_EV-1:0] ev_pulse,
   input  logic              rd_xact_v,
   input  logic [ID_W-1:0]   rd_xact_id,
   input  logic              wr_xact_v,
   input  logic [ID_W-1:0]   wr_xact_id,
   output logic              irq
);
   localparam logic [CNT_W-1:0]  CMAX   = {CNT_W{1'b1}};
   localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(FILT_OFF);

   generate
      if (NUM_CNT < 2 || NUM_CNT > 4) begin : g_bad_cnt
         $error("NUM_CNT must be 2..4 to fit the register map");
      end
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_w
         $error("CNT_W must be 2..32");
      end
      if (ID_W < 1 || ID_W > BUS_W) begin : g_bad_id
         $error("ID_W must be 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_a
         $error("ADDR_W must be at least 6");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_w  [NUM_CNT];
   mpc_stat_t        stat_w [NUM_CNT];
   logic [ID_W-1:0]  match_q;
   logic             wr_go;
   logic             unused_wdata;

   assign wr_go        = bus_sel && bus_wr;
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            match_q <= '0;
      else if (wr_go && bus_addr == A_FILT)  match_q <= bus_wdata[ID_W-1:0];
   end

   generate
      for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
         localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + 4*n);
         logic wr_here;
         logic hit;
         assign wr_here = wr_go && (bus_addr == A_CTRL);

         if (n == 0) begin : g_master
            assign hit = 1'b1;
            mpc_slice #(.CNT_W(CNT_W), .IS_CYCLE(1'b1)) i_slice (
               .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_here),
               .wr_en_i(bus_wdata[EN_BIT]), .wr_clr_i(bus_wdata[CLR_BIT]),
               .wr_ovf_i(bus_wdata[OVF_BIT]),
               .wr_sel_i(bus_wdata[SEL_LSB +: CODE_W]),
               .gate_i(1'b1), .hit_i(hit),
               .cnt_o(cnt_w[n]), .stat_o(stat_w[n]));
         end else begin : g_event
            mpc_evsel #(.ID_W(ID_W)) i_evsel (
               .code_i(stat_w[n].sel), .ev_pulse_i(ev_pulse),
               .rd_xact_v_i(rd_xact_v), .rd_xact_id_i(rd_xact_id),
               .wr_xact_v_i(wr_xact_v), .wr_xact_id_i(wr_xact_id),
               .match_id_i(match_q), .hit_o(hit));
            mpc_slice #(.CNT_W(CNT_W), .IS_CYCLE(1'b0)) i_slice (
               .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_here),
               .wr_en_i(bus_wdata[EN_BIT]), .wr_clr_i(bus_wdata[CLR_BIT]),
               .wr_ovf_i(bus_wdata[OVF_BIT]),
               .wr_sel_i(bus_wdata[SEL_LSB +: CODE_W]),
               .gate_i(stat_w[0].en), .hit_i(hit),
               .cnt_o(cnt_w[n]), .stat_o(stat_w[n]));
         end
      end
   endgenerate

   logic [BUS_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int n = 0; n < NUM_CNT; n++) begin
         if (bus_addr == ADDR_W'(CTRL_BASE + 4*n)) begin
            rd_next[SEL_LSB +: CODE_W] = stat_w[n].sel;
            rd_next[EN_BIT]            = stat_w[n].en;
            rd_next[OVF_BIT]           = stat_w[n].ovf;
         end
         if (bus_addr == ADDR_W'(VAL_BASE + 4*n)) begin
            rd_next[CNT_W-1:0] = cnt_w[n];
         end
      end
      if (bus_addr == A_FILT) rd_next[ID_W-1:0] = match_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_sel && !bus_wr;
         if (bus_sel && !bus_wr) bus_rdata <= rd_next;
      end
   end

   assign irq = stat_w[0].ovf;

   assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |=> bus_rvalid);

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(cnt_w[0] == CMAX) && $past(stat_w[0].en)));

   assert_irq_only_master_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(stat_w[0].en));
endmodule

// File: tb/test_mpc_perfmon.sv
`timescale 1ns/1ps
module test_mpc_perfmon;
   localparam int CW = 8;
   localparam int IW = 4;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic [4:0]    ev_pulse = '0;
   logic          rd_xact_v = 1'b0;
   logic [IW-1:0] rd_xact_id = '0;
   logic          wr_xact_v = 1'b0;
   logic [IW-1:0] wr_xact_id = '0;
   logic          irq;

   always #2.5 clk = ~clk;

   mpc_perfmon #(.NUM_CNT(NC), .CNT_W(CW), .ID_W(IW), .ADDR_W(8)) i_mpc_perfmon (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .ev_pulse(ev_pulse), .rd_xact_v(rd_xact_v),
      .rd_xact_id(rd_xact_id), .wr_xact_v(wr_xact_v), .wr_xact_id(wr_xact_id),
      .irq(irq));

   typedef struct {
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t  sbq[$];
   int    errors = 0;
   int    checks = 0;
   string cur_tag = "R1";
   logic  ev_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic fail(input string tag, input logic [31:0] act, input logic [31:0] exp);
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
   endtask

   // ---------------- reference model (from the requirements) -------------
   logic [CW-1:0] m_cnt [NC];
   logic          m_en  [NC];
   logic [7:0]    m_sel [NC];
   logic          m_ovf;
   logic [IW-1:0] m_filt;

   function automatic logic m_hit(input logic [7:0] c);
      case (c)
         8'h00:   return 1'b1;
         8'h04:   return ev_pulse[0];
         8'h05:   return ev_pulse[1];
         8'h31:   return ev_pulse[2];
         8'h32:   return ev_pulse[3];
         8'h37:   return ev_pulse[4];
         8'h41:   return rd_xact_v && (rd_xact_id == m_filt);
         8'h42:   return wr_xact_v && (wr_xact_id == m_filt);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      for (int n = 0; n < NC; n++) begin
         if (a == 8'(4*n))
            return {m_sel[n], 21'b0, m_en[n], 1'b0, (n == 0) ? m_ovf : 1'b0};
         if (a == 8'('h20 + 4*n))
            return 32'(m_cnt[n]);
      end
      if (a == 8'h30) return 32'(m_filt);
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < NC; n++) begin
            m_cnt[n] <= '0;
            m_en[n]  <= 1'b0;
            m_sel[n] <= '0;
         end
         m_ovf  <= 1'b0;
         m_filt <= '0;
      end else begin
         if (bus_sel && !bus_wr) sbq.push_back('{m_read(bus_addr), cur_tag});
         if (bus_sel && bus_wr && bus_addr == 8'h30) m_filt <= bus_wdata[IW-1:0];
         for (int n = 0; n < NC; n++) begin
            logic wc, st, sp, inc, wrp;
            wc  = bus_sel && bus_wr && (bus_addr == 8'(4*n));
            st  = wc && bus_wdata[2] && !m_en[n];
            sp  = wc && !bus_wdata[2];
            inc = m_en[n] && ((n == 0) || (m_en[0] && m_hit(m_sel[n])));
            wrp = inc && (m_cnt[n] == '1);
            if (st) begin
               m_en[n] <= 1'b1;
               if (n != 0) m_sel[n] <= bus_wdata[31:24];
               if (bus_wdata[1]) m_cnt[n] <= '0;
            end else if (sp) begin
               m_en[n] <= 1'b0;
            end else if (inc) begin
               m_cnt[n] <= m_cnt[n] + 1'b1;
               if (n == 0 && wrp) m_en[n] <= 1'b0;
            end
            if (n == 0) begin
               if (wrp) m_ovf <= 1'b1;
               else if (st || (wc && bus_wdata[0])) m_ovf <= 1'b0;
            end
         end
      end
   end

   // ---------------- stimulus for controller events ----------------------
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ev_on) begin
         ev_pulse   = lfsr[4:0];
         rd_xact_v  = lfsr[5];
         rd_xact_id = lfsr[9:6];
         wr_xact_v  = lfsr[10];
         wr_xact_id = lfsr[14:11];
      end else begin
         ev_pulse  = '0;
         rd_xact_v = 1'b0;
         wr_xact_v = 1'b0;
      end
   end

   // ---------------- monitor: irq level and read scoreboard --------------
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq !== m_ovf) fail("R10 irq level (R12 no event irq)", 32'(irq), 32'(m_ovf));
         if (bus_rvalid) begin
            if (sbq.size() == 0) begin
               checks++;
               fail("R2 rvalid without read", 32'(bus_rvalid), 32'h0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               checks++;
               if (bus_rdata !== e.data) fail(e.tag, bus_rdata, e.data);
            end
         end
      end
   end

   // ---------------- driver tasks ----------------------------------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      cur_tag = tag;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] codes [3];
      codes[0] = 8'h31; codes[1] = 8'h32; codes[2] = 8'h05;

      idle(4);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state of every register
      for (int n = 0; n < NC; n++) rd(8'(4*n), "R1");
      for (int n = 0; n < NC; n++) rd(8'('h20 + 4*n), "R1");
      rd(8'h30, "R1");
      // R2 unmapped offsets read zero
      rd(8'h1C, "R2");
      rd(8'h34, "R2");
      rd(8'h3C, "R2");
      wr(8'h30, 32'hFFFF_FFF5);
      rd(8'h30, "R2");

      ev_on = 1'b1;
      wr(8'h04, 32'h0400_0006);
      wr(8'h08, 32'h4100_0006);
      wr(8'h0C, 32'h3700_0006);
      idle(10);
      rd(8'h24, "R7");                  // master stopped: still zero
      wr(8'h00, 32'hAB00_0006);         // code bits ignored for counter 0
      idle(20);
      rd(8'h20, "R6");
      rd(8'h24, "R8");
      rd(8'h28, "R9");
      rd(8'h2C, "R8");
      rd(8'h00, "R3");
      rd(8'h04, "R3");

      wr(8'h04, 32'h0500_0006);         // already enabled: no restart
      rd(8'h04, "R5");
      rd(8'h24, "R5");

      wr(8'h00, 32'h0);                 // stop master
      idle(5);
      rd(8'h24, "R7");
      rd(8'h2C, "R7");
      idle(10);
      rd(8'h24, "R7");
      rd(8'h20, "R7");

      wr(8'h00, 32'h4);                 // resume without clear
      idle(10);
      rd(8'h20, "R4");

      wr(8'h04, 32'h0);
      wr(8'h04, 32'h9900_0006);         // unknown code
      idle(20);
      rd(8'h24, "R8");
      wr(8'h08, 32'h0);
      wr(8'h08, 32'h4200_0006);
      idle(30);
      rd(8'h28, "R9");
      wr(8'h30, 32'hA);
      idle(30);
      rd(8'h28, "R9");
      for (int k = 0; k < 3; k++) begin
         wr(8'h0C, 32'h0);
         wr(8'h0C, {codes[k], 24'h000006});
         idle(15);
         rd(8'h2C, "R8");
      end

      // master from zero, counter 1 counting cycles a few clocks behind
      wr(8'h00, 32'h0);
      wr(8'h00, 32'h6);
      wr(8'h04, 32'h0);
      wr(8'h04, 32'h0000_0006);
      idle(300);
      rd(8'h00, "R10");
      rd(8'h20, "R10");
      rd(8'h24, "R10");
      idle(10);
      rd(8'h24, "R10");

      wr(8'h00, 32'h1);                 // write-one-to-clear flag
      rd(8'h00, "R11");
      wr(8'h00, 32'h6);
      idle(20);
      rd(8'h24, "R12");                 // wrapped and kept counting
      rd(8'h20, "R11");

      idle(300);
      rd(8'h00, "R10");
      wr(8'h00, 32'h4);                 // re-enable clears flag, resumes
      rd(8'h00, "R11");
      idle(5);
      rd(8'h20, "R11");
      idle(4);

      checks++;
      if (sbq.size() != 0) fail("R2 missing read data", 32'(sbq.size()), 32'h0);
      summary();
      $finish;
   end
endmodule